// File: doc/BRIEF.md
# Dynamic Bus-Width External Bus Sequencer

This block sits between a CPU core and an external memory bus that is divided into eight chip-select regions. The CPU presents a request: an address, a transfer size (byte, word or long word), a direction, write data and the one-hot vector of chip-select regions that claim the address. The block then runs as many external bus cycles as the transfer needs. A read is returned to the CPU as one right-justified value, followed by a single-cycle acknowledge.

Each region drives either a 16-bit or an 8-bit port. Regions 0 to 6 take their width from a software-written width register. Region 7 is the boot region. Its width comes from a strap pin that is sampled on every reset cycle and frozen when reset is released. Each external cycle lasts three or four clocks plus a programmable number of wait states. A transfer that is wider than the port is split into sub-cycles. The most significant part goes first, and the address climbs by the port width on each sub-cycle.

Top module: `extbus_sizer`

## Requirements
- R1: After reset the width register reads 0 (all programmable regions 16-bit), `bus_strobe` is low and `ack` is low.
- R2: A write on the configuration port loads bits 6..0 of the width register. Bit 7 always reads 0. A bit value of 1 makes its region (0..6) an 8-bit port and 0 makes it a 16-bit port.
- R3: Region 7 is an 8-bit port when `boot_narrow` was 1 in the last reset cycle. Changes of the pin after reset have no effect.
- R4: The port width is fixed when a request is accepted. A width-register write made while the transfer runs affects only later transfers.
- R5: The number of sub-cycles depends on size and port width. `req_size` encodes 0 = byte, 1 = word, 2 or 3 = long word. A byte takes 1 sub-cycle. A word takes 1 sub-cycle on a 16-bit port and 2 on an 8-bit port. A long word takes 2 sub-cycles on a 16-bit port and 4 on an 8-bit port.
- R6: Sub-cycles move the most significant part first. `bus_addr` starts at the request address and rises by 1 (8-bit port) or 2 (16-bit port) per sub-cycle.
- R7: On an 8-bit port only `bus_lane_lo` is asserted and data travels on bits 7..0 only. Read data on bits 15..8 is ignored.
- R8: A byte on a 16-bit port uses the upper lane (bits 15..8, `bus_lane_hi`) for an even address and the lower lane (bits 7..0, `bus_lane_lo`) for an odd address. Word and long-word transfers on a 16-bit port assert both lanes.
- R9: Each sub-cycle keeps `bus_strobe` high for 3 clocks (when `fast_cycle`=1 and the transfer is a read) or 4 clocks (otherwise), plus `wait_states` clocks.
- R10: Read data is returned right-justified in `rdata`, with the first sub-cycle's data most significant. `ack` is a one-clock pulse in the cycle after the last strobe clock: N strobe clocks give `ack` N clocks after the accepting edge.
- R11: Write data is captured when the request is accepted. Later changes of `req_wdata` do not change the bytes driven on the bus.
- R12: If zero or more than one chip-select bit is set, the transfer uses a 16-bit port and `ack_err` is high together with `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_narrow | input | 1 | Boot region width strap, 1 = 8-bit, sampled during reset |
| cfg_we | input | 1 | Width register write enable |
| cfg_wdata | input | NUM_CS | Width register write data |
| cfg_rdata | output | NUM_CS | Width register read value, top bit zero |
| fast_cycle | input | 1 | Shortens read cycles to 3 base clocks |
| wait_states | input | WAIT_W | Extra clocks per sub-cycle |
| req_valid | input | 1 | CPU request present, sampled while idle |
| req_addr | input | ADDR_W | Transfer start address |
| req_size | input | 2 | 0 byte, 1 word, 2/3 long word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write data |
| req_cs | input | NUM_CS | Chip-select hit vector |
| ack | output | 1 | One-clock transfer completion pulse |
| ack_err | output | 1 | Chip-select fault flag, valid with ack |
| rdata | output | 32 | Right-justified read data |
| bus_addr | output | ADDR_W | External address |
| bus_strobe | output | 1 | External cycle active |
| bus_write | output | 1 | External cycle direction |
| bus_dout | output | 16 | External write data |
| bus_din | input | 16 | External read data |
| bus_lane_hi | output | 1 | Bits 15..8 lane enable |
| bus_lane_lo | output | 1 | Bits 7..0 lane enable |

## Verification
If the latched width or sub-cycle count is wrong, the number of distinct addresses on `bus_addr` during a transfer is wrong, and `ack` arrives early or late by whole sub-cycles. Both show within the transfer in question. If a lane choice or the assembly order is wrong, the bytes captured on the bus or the returned `rdata` are permuted, and this shows at the `ack` of that transfer. A faulty boot-strap latch or width register shows only on the first transfer to the affected region. For that reason, region 7 and each reprogrammed region are exercised directly after the change.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int CPU_DW = 32;
  localparam int BUS_DW = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [BUS_DW-1:0] dout;
    logic              hi;
    logic              lo;
  } lane_drv_t;
endpackage

// File: rtl/xbs_width_reg.sv
module xbs_width_reg #(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_narrow,
  input  logic              cfg_we,
  input  logic [NUM_CS-1:0] cfg_wdata,
  output logic [NUM_CS-1:0] width_map,
  output logic [NUM_CS-1:0] cfg_rdata
);
  localparam int PROG = NUM_CS - 1;

  logic [PROG-1:0] prog_q;
  logic            boot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= '0;
      boot_q <= boot_narrow;
    end else if (cfg_we) begin
      prog_q <= cfg_wdata[PROG-1:0];
    end
  end

  assign width_map = {boot_q, prog_q};
  assign cfg_rdata = {1'b0, prog_q};

  // boot width frozen once reset is released
  assert_boot_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(boot_q));

  // a write lands in the register on the next edge
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata[PROG-1:0] == $past(cfg_wdata[PROG-1:0]));
endmodule

// File: rtl/xbs_width_sel.sv
module xbs_width_sel #(
  parameter int NUM_CS = 8
) (
  input  logic [NUM_CS-1:0] cs_hit,
  input  logic [NUM_CS-1:0] width_map,
  output logic              narrow,
  output logic              cs_err
);
  localparam int CNT_W = $clog2(NUM_CS + 1);

  logic [CNT_W-1:0] hit_cnt;
  logic             narrow_any;

  always_comb begin
    hit_cnt    = '0;
    narrow_any = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_hit[i]) begin
        hit_cnt    = hit_cnt + CNT_W'(1);
        narrow_any = narrow_any | width_map[i];
      end
    end
    cs_err = (hit_cnt != CNT_W'(1));
    narrow = !cs_err && narrow_any;
  end
endmodule

// File: rtl/xbs_seq.sv
module xbs_seq import xbs_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_cycle,
  input  logic [WAIT_W-1:0] wait_states,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [CPU_DW-1:0] req_wdata,
  input  logic              req_narrow,
  input  logic              req_err,
  output logic              ack,
  output logic              ack_err,
  output logic [CPU_DW-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [BUS_DW-1:0] bus_dout,
  input  logic [BUS_DW-1:0] bus_din,
  output logic              bus_lane_hi,
  output logic              bus_lane_lo
);
  localparam int LEN_W = WAIT_W + 2;

  function automatic logic [2:0] nsub_of(input logic [1:0] sz, input logic nar);
    if (sz == SZ_BYTE)      return 3'd1;
    else if (sz == SZ_WORD) return nar ? 3'd2 : 3'd1;
    else                    return nar ? 3'd4 : 3'd2;
  endfunction

  function automatic lane_drv_t lane_plan(input logic [CPU_DW-1:0] wd,
                                          input logic [1:0] sz, input logic nar,
                                          input logic [2:0] idx, input logic [2:0] n,
                                          input logic odd);
    lane_drv_t         d;
    logic [2:0]        rem;
    logic [CPU_DW-1:0] sh;
    rem = n - 3'd1 - idx;
    if (nar) begin
      sh     = wd >> ({2'b00, rem} << 3);
      d.dout = {8'h00, sh[7:0]};
      d.hi   = 1'b0;
      d.lo   = 1'b1;
    end else if (sz == SZ_BYTE) begin
      d.dout = {wd[7:0], wd[7:0]};
      d.hi   = !odd;
      d.lo   = odd;
    end else begin
      sh     = wd >> ({2'b00, rem} << 4);
      d.dout = sh[BUS_DW-1:0];
      d.hi   = 1'b1;
      d.lo   = 1'b1;
    end
    return d;
  endfunction

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              write_q, narrow_q, err_q;
  logic [CPU_DW-1:0] wdata_q, hold_q, hold_nx, rdata_q;
  logic [2:0]        nsub_q, sub_q;
  logic [LEN_W-1:0]  len_q, cnt_q, len_nx;
  logic [7:0]        byte_in;
  logic              strobe_q, lane_hi_q, lane_lo_q, ack_q, ack_err_q;
  logic [BUS_DW-1:0] dout_q;
  lane_drv_t         first_drv, next_drv;
  logic [ADDR_W-1:0] step;
  logic [2:0]        req_nsub;

  assign req_nsub  = nsub_of(req_size, req_narrow);
  assign first_drv = lane_plan(req_wdata, req_size, req_narrow, 3'd0, req_nsub, req_addr[0]);
  assign next_drv  = lane_plan(wdata_q, size_q, narrow_q, sub_q + 3'd1, nsub_q, addr_q[0]);
  assign step      = narrow_q ? ADDR_W'(1) : ADDR_W'(2);
  assign len_nx    = ((fast_cycle && !req_write) ? LEN_W'(3) : LEN_W'(4)) + LEN_W'(wait_states);

  always_comb begin
    if (narrow_q || addr_q[0]) byte_in = bus_din[7:0];
    else                       byte_in = bus_din[15:8];
    if (narrow_q || size_q == SZ_BYTE) hold_nx = {hold_q[CPU_DW-9:0], byte_in};
    else                               hold_nx = {hold_q[CPU_DW-BUS_DW-1:0], bus_din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      size_q    <= '0;
      write_q   <= 1'b0;
      narrow_q  <= 1'b0;
      err_q     <= 1'b0;
      wdata_q   <= '0;
      hold_q    <= '0;
      rdata_q   <= '0;
      nsub_q    <= 3'd1;
      sub_q     <= '0;
      len_q     <= LEN_W'(4);
      cnt_q     <= '0;
      strobe_q  <= 1'b0;
      lane_hi_q <= 1'b0;
      lane_lo_q <= 1'b0;
      dout_q    <= '0;
      ack_q     <= 1'b0;
      ack_err_q <= 1'b0;
    end else begin
      ack_q     <= 1'b0;
      ack_err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q    <= req_addr;
            size_q    <= req_size;
            write_q   <= req_write;
            narrow_q  <= req_narrow;
            err_q     <= req_err;
            wdata_q   <= req_wdata;
            nsub_q    <= req_nsub;
            len_q     <= len_nx;
            sub_q     <= '0;
            cnt_q     <= '0;
            hold_q    <= '0;
            strobe_q  <= 1'b1;
            lane_hi_q <= first_drv.hi;
            lane_lo_q <= first_drv.lo;
            dout_q    <= req_write ? first_drv.dout : '0;
            state_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt_q == len_q - LEN_W'(1)) begin
            if (!write_q) hold_q <= hold_nx;
            if (sub_q == nsub_q - 3'd1) begin
              strobe_q  <= 1'b0;
              lane_hi_q <= 1'b0;
              lane_lo_q <= 1'b0;
              ack_q     <= 1'b1;
              ack_err_q <= err_q;
              rdata_q   <= write_q ? '0 : hold_nx;
              state_q   <= ST_DONE;
            end else begin
              sub_q     <= sub_q + 3'd1;
              cnt_q     <= '0;
              addr_q    <= addr_q + step;
              lane_hi_q <= next_drv.hi;
              lane_lo_q <= next_drv.lo;
              dout_q    <= write_q ? next_drv.dout : '0;
            end
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack         = ack_q;
  assign ack_err     = ack_err_q;
  assign rdata       = rdata_q;
  assign bus_addr    = addr_q;
  assign bus_strobe  = strobe_q;
  assign bus_write   = write_q;
  assign bus_dout    = dout_q;
  assign bus_lane_hi = lane_hi_q;
  assign bus_lane_lo = lane_lo_q;

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_ack_bus_idle_R10: assert property (@(posedge clk) disable iff (rst)
    ack |-> !bus_strobe);

  assert_narrow_lane_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && narrow_q) |-> (bus_lane_lo && !bus_lane_hi));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && $past(bus_strobe) && bus_addr != $past(bus_addr))
      |-> bus_addr == $past(bus_addr) + step);

  assert_sub_bound_R5: assert property (@(posedge clk) disable iff (rst)
    bus_strobe |-> (sub_q < nsub_q));

  assert_strobe_len_R9: assert property (@(posedge clk) disable iff (rst)
    bus_strobe |-> (cnt_q < len_q));
endmodule

// File: rtl/extbus_sizer.sv
module extbus_sizer import xbs_pkg::*; #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_narrow,
  input  logic              cfg_we,
  input  logic [NUM_CS-1:0] cfg_wdata,
  output logic [NUM_CS-1:0] cfg_rdata,
  input  logic              fast_cycle,
  input  logic [WAIT_W-1:0] wait_states,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [CPU_DW-1:0] req_wdata,
  input  logic [NUM_CS-1:0] req_cs,
  output logic              ack,
  output logic              ack_err,
  output logic [CPU_DW-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [BUS_DW-1:0] bus_dout,
  input  logic [BUS_DW-1:0] bus_din,
  output logic              bus_lane_hi,
  output logic              bus_lane_lo
);
  logic [NUM_CS-1:0] width_map;
  logic              sel_narrow, sel_err;

  xbs_width_reg #(.NUM_CS(NUM_CS)) u_wreg (
    .clk(clk), .rst(rst), .boot_narrow(boot_narrow),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .width_map(width_map), .cfg_rdata(cfg_rdata)
  );

  xbs_width_sel #(.NUM_CS(NUM_CS)) u_wsel (
    .cs_hit(req_cs), .width_map(width_map),
    .narrow(sel_narrow), .cs_err(sel_err)
  );

  xbs_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst(rst),
    .fast_cycle(fast_cycle), .wait_states(wait_states),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata),
    .req_narrow(sel_narrow), .req_err(sel_err),
    .ack(ack), .ack_err(ack_err), .rdata(rdata),
    .bus_addr(bus_addr), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_lane_hi(bus_lane_hi), .bus_lane_lo(bus_lane_lo)
  );
endmodule

// File: tb/sim_extbus_sizer.sv
module sim_extbus_sizer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_narrow = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        fast_cycle = 1'b0;
  logic [3:0]  wait_states = '0;
  logic        req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  req_cs = '0;
  logic        ack, ack_err;
  logic [31:0] rdata;
  logic [AW-1:0] bus_addr;
  logic        bus_strobe, bus_write, bus_lane_hi, bus_lane_lo;
  logic [15:0] bus_dout, bus_din;
  logic        cur_narrow = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [6:0] cfg_model = '0;
  logic       boot_model = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign bus_din = cur_narrow ? {8'hEE, mem_byte(bus_addr)}
                              : {mem_byte({bus_addr[AW-1:1], 1'b0}), mem_byte({bus_addr[AW-1:1], 1'b1})};

  extbus_sizer u0 (
    .clk(clk), .rst(rst), .boot_narrow(boot_narrow),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fast_cycle(fast_cycle), .wait_states(wait_states),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .req_cs(req_cs),
    .ack(ack), .ack_err(ack_err), .rdata(rdata),
    .bus_addr(bus_addr), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_lane_hi(bus_lane_hi), .bus_lane_lo(bus_lane_lo)
  );

  // bus monitor: counts strobe clocks, sub-cycles and captured write bytes
  int sub_seen = 0;
  int strobe_seen = 0;
  int lane_bad = 0;
  int wr_idx = 0;
  logic [AW-1:0] wr_addr [0:255];
  logic [7:0]    wr_byte [0:255];
  logic          prev_strobe = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin
    if (bus_strobe) begin
      strobe_seen <= strobe_seen + 1;
      if (cur_narrow && (bus_lane_hi || !bus_lane_lo)) lane_bad <= lane_bad + 1;
      if (!prev_strobe || bus_addr != prev_addr) begin
        sub_seen <= sub_seen + 1;
        if (bus_write) begin
          if (cur_narrow) begin
            wr_addr[wr_idx[7:0]] <= bus_addr;
            wr_byte[wr_idx[7:0]] <= bus_dout[7:0];
            wr_idx <= wr_idx + 1;
          end else if (bus_lane_hi && bus_lane_lo) begin
            wr_addr[wr_idx[7:0]]       <= {bus_addr[AW-1:1], 1'b0};
            wr_byte[wr_idx[7:0]]       <= bus_dout[15:8];
            wr_addr[wr_idx[7:0] + 8'd1] <= {bus_addr[AW-1:1], 1'b1};
            wr_byte[wr_idx[7:0] + 8'd1] <= bus_dout[7:0];
            wr_idx <= wr_idx + 2;
          end else if (bus_lane_hi) begin
            wr_addr[wr_idx[7:0]] <= {bus_addr[AW-1:1], 1'b0};
            wr_byte[wr_idx[7:0]] <= bus_dout[15:8];
            wr_idx <= wr_idx + 1;
          end else if (bus_lane_lo) begin
            wr_addr[wr_idx[7:0]] <= {bus_addr[AW-1:1], 1'b1};
            wr_byte[wr_idx[7:0]] <= bus_dout[7:0];
            wr_idx <= wr_idx + 1;
          end
        end
      end
    end
    prev_strobe <= bus_strobe;
    prev_addr   <= bus_addr;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_narrow(input logic [7:0] cs);
    if ($countones(cs) != 1) return 1'b0;
    for (int i = 0; i < 7; i++) if (cs[i]) return cfg_model[i];
    return boot_model;
  endfunction

  function automatic int exp_nsub(input logic [1:0] sz, input logic nar);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return nar ? 2 : 1;
    return nar ? 4 : 2;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return 2;
    return 4;
  endfunction

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = v[6:0];
  endtask

  task automatic run_xfer(input logic [AW-1:0] a, input logic [1:0] sz, input logic wr,
                          input logic [31:0] wd, input logic [7:0] cs, input logic [3:0] ws,
                          input logic fast, input bit mid_cfg, input logic [7:0] cfg_val);
    int n, len, k, sc0, st0, wi0, lb0, nb;
    logic nar, er;
    logic [31:0] exp;
    er  = ($countones(cs) != 1);
    nar = exp_narrow(cs);
    n   = exp_nsub(sz, nar);
    len = ((fast && !wr) ? 3 : 4) + int'(ws);
    nb  = nbytes(sz);
    cur_narrow = nar;
    sc0 = sub_seen; st0 = strobe_seen; wi0 = wr_idx; lb0 = lane_bad;
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_cs = cs;
    wait_states = ws; fast_cycle = fast; req_valid = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        req_wdata = ~wd;  // R11: late change must not reach the bus
        req_cs = ~cs;
      end
      if (mid_cfg && k == 2) begin cfg_we = 1'b1; cfg_wdata = cfg_val; end
      if (k == 3) cfg_we = 1'b0;
    end while (!ack && k < 400);
    req_valid = 1'b0;
    cfg_we = 1'b0;
    if (mid_cfg) cfg_model = cfg_val[6:0];
    chk(k == n*len + 1, "R10 ack latency", k, n*len + 1);
    chk(sub_seen - sc0 == n, "R5 sub-cycle count", sub_seen - sc0, n);
    chk(strobe_seen - st0 == n*len, "R9 strobe clocks", strobe_seen - st0, n*len);
    chk(ack_err == er, "R12 error flag", {31'd0, ack_err}, {31'd0, er});
    chk(lane_bad == lb0, "R7 narrow lanes", lane_bad - lb0, 0);
    if (!wr) begin
      exp = '0;
      for (int j = 0; j < nb; j++) exp = (exp << 8) | {24'd0, mem_byte(a + AW'(j))};
      chk(rdata == exp, "R6 R8 read assembly", rdata, exp);
    end else begin
      chk(wr_idx - wi0 == nb, "R8 write byte count", wr_idx - wi0, nb);
      for (int j = 0; j < nb; j++) begin
        logic [7:0] eb;
        eb = 8'((wd >> (8*(nb-1-j))));
        chk(wr_addr[8'(wi0 + j)] == a + AW'(j) && wr_byte[8'(wi0 + j)] == eb,
            "R6 R11 write byte", {wr_addr[8'(wi0 + j)][23:0], wr_byte[8'(wi0 + j)]},
            {a + AW'(j), eb});
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    boot_narrow = 1'b0;  // R3: post-reset change ignored
    chk(cfg_rdata == 8'h00, "R1 width reg reset", cfg_rdata, 8'h00);
    chk(!bus_strobe && !ack, "R1 idle outputs", {bus_strobe, ack}, 0);

    cfg_write(8'hFF);
    chk(cfg_rdata == 8'h7F, "R2 reserved bit", cfg_rdata, 8'h7F);
    cfg_write(8'h00);
    chk(cfg_rdata == 8'h00, "R2 clear", cfg_rdata, 8'h00);

    run_xfer(24'h001230, 2'd1, 1'b0, 0, 8'h01, 4'd0, 1'b1, 0, 0);            // R5 word 16-bit
    run_xfer(24'h004560, 2'd0, 1'b0, 0, 8'h01, 4'd1, 1'b0, 0, 0);            // R8 even byte
    run_xfer(24'h004561, 2'd0, 1'b0, 0, 8'h01, 4'd0, 1'b1, 0, 0);            // R8 odd byte
    run_xfer(24'h004562, 2'd0, 1'b1, 32'h000000A5, 8'h01, 4'd0, 1'b0, 0, 0); // R8 even write
    run_xfer(24'h004563, 2'd0, 1'b1, 32'h0000005A, 8'h01, 4'd2, 1'b0, 0, 0); // R8 odd write
    run_xfer(24'h000100, 2'd1, 1'b0, 0, 8'h80, 4'd0, 1'b1, 0, 0);            // R3 boot narrow
    run_xfer(24'h000200, 2'd2, 1'b1, 32'hDEADBEEF, 8'h80, 4'd0, 1'b0, 0, 0); // R3 R7
    cfg_write(8'h02);
    run_xfer(24'h003000, 2'd2, 1'b0, 0, 8'h02, 4'd1, 1'b1, 0, 0);            // R2 narrow long
    run_xfer(24'h003100, 2'd2, 1'b1, 32'h01234567, 8'h02, 4'd0, 1'b0, 0, 0);
    run_xfer(24'h005000, 2'd2, 1'b0, 0, 8'h00, 4'd0, 1'b0, 0, 0);            // R12 no hit
    run_xfer(24'h005100, 2'd2, 1'b0, 0, 8'h06, 4'd0, 1'b0, 0, 0);            // R12 multi hit
    run_xfer(24'h006000, 2'd2, 1'b1, 32'hCAFEF00D, 8'h04, 4'd0, 1'b0, 1, 8'h06); // R4 mid write
    run_xfer(24'h006100, 2'd2, 1'b1, 32'h89ABCDEF, 8'h04, 4'd0, 1'b0, 0, 0); // R4 next narrow

    for (int it = 0; it < 60; it++) begin
      logic [7:0] cs;
      logic [1:0] sz;
      logic [AW-1:0] a;
      if (it % 10 == 0) cfg_write(8'($urandom));
      r = $urandom;
      if (r[2:0] < 3'd6) cs = 8'h01 << (($urandom) % 8);
      else if (r[2:0] == 3'd6) cs = 8'h00;
      else cs = 8'h11;
      sz = 2'(($urandom) % 3);
      a = AW'($urandom);
      if (sz != 2'd0) a[0] = 1'b0;
      run_xfer(a, sz, r[3], $urandom, cs, 4'(r[5:4]), r[6], 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule